// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two parallel buses, A and B, through a set of independent lanes. Each lane carries one storage register per direction. The A-to-B register samples the A bus on a rising edge of its own capture clock. The B-to-A register samples the B bus on a rising edge of a second capture clock. For each direction, a select bit decides what the driven bus receives: either the live value from the opposite bus, passed through combinationally, or the value held in that direction's register.

Each lane has an isolate bit and a direction bit, which together decide which bus the lane drives, if it drives either. Tri-state pins are modelled as an input vector, an output vector and one output-enable bit per bus per lane. The registers keep sampling whether the lane is isolated or driving. Sampling the undriven side while the other side is driven is part of normal use. With the default parameters, two 8-bit lanes with separate control sets form a 16-bit path.

Top module: `xcvr_regbus`

## Requirements
- R1: A rising edge of `cap_ab[k]` loads lane k's A-to-B register with `a_in[k*WIDTH +: WIDTH]`. A rising edge of `cap_ba[k]` loads lane k's B-to-A register with `b_in[k*WIDTH +: WIDTH]`. Both may happen on the same edge.
- R2: Loading happens on every capture edge regardless of `isolate` and `dir_to_b`. This includes loading while isolated and loading the undriven side while the other side is driven.
- R3: Without a rising edge on its capture clock, a register keeps its value when bus inputs change.
- R4: When `isolate[k]` is 1, both `a_oe[k]` and `b_oe[k]` are 0.
- R5: When `isolate[k]` is 0, `dir_to_b[k]`=0 gives `a_oe[k]`=1 and `b_oe[k]`=0, and `dir_to_b[k]`=1 gives `b_oe[k]`=1 and `a_oe[k]`=0.
- R6: Lane k's `a_out` slice equals the live `b_in` slice in the same cycle when `sel_ba[k]`=0. It equals the B-to-A register when `sel_ba[k]`=1. This holds whether or not `a_oe[k]` is set.
- R7: Lane k's `b_out` slice equals the live `a_in` slice when `sel_ab[k]`=0, and the A-to-B register when `sel_ab[k]`=1.
- R8: `a_oe[k]` and `b_oe[k]` are never both 1.
- R9: Lanes are independent. Lane k uses only bit k of every control vector and bits `[k*WIDTH +: WIDTH]` of every data vector.
- R10: If `rst` is 1 at a capture edge, that edge clears the register it clocks to zero instead of loading it. Registers whose clocks do not rise are untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Synchronous active-high clear, taken at capture edges |
| isolate | input | CHANNELS | Per lane: 1 drives neither bus |
| dir_to_b | input | CHANNELS | Per lane: 1 drives B, 0 drives A (when not isolated) |
| sel_ab | input | CHANNELS | Per lane: B output takes the stored A-to-B value when 1 |
| sel_ba | input | CHANNELS | Per lane: A output takes the stored B-to-A value when 1 |
| cap_ab | input | CHANNELS | Per lane: rising edge loads the A-to-B register |
| cap_ba | input | CHANNELS | Per lane: rising edge loads the B-to-A register |
| a_in | input | CHANNELS*WIDTH | A bus as seen at the pins |
| b_in | input | CHANNELS*WIDTH | B bus as seen at the pins |
| a_out | output | CHANNELS*WIDTH | Value offered to the A bus |
| b_out | output | CHANNELS*WIDTH | Value offered to the B bus |
| a_oe | output | CHANNELS | Per lane: A bus driver enable |
| b_oe | output | CHANNELS | Per lane: B bus driver enable |

## Verification
The bench builds the block with WIDTH=4 and CHANNELS=2. This narrow data width lets every data pair on a lane be swept against all sixteen combinations of isolate, direction and both selects. The other lane is held steady during the sweep, so any cross-lane leakage shows up. The second lane also brings the per-lane independence of capture clocks and reset into reach.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
    timeunit 1ns;
    timeprecision 100ps;

    typedef struct packed {
        logic isolate;
        logic dir_to_b;
        logic stored_to_b;
        logic stored_to_a;
    } lane_ctl_t;

    typedef enum logic [1:0] {
        DRV_NONE = 2'd0,
        DRV_A    = 2'd1,
        DRV_B    = 2'd2
    } drive_t;

    function automatic drive_t drive_of(input lane_ctl_t c);
        if (c.isolate) begin
            return DRV_NONE;
        end
        return c.dir_to_b ? DRV_B : DRV_A;
    endfunction
endpackage

// File: rtl/xcvr_store_reg.sv
module xcvr_store_reg #(
    parameter int WIDTH = 8
) (
    input  logic             cap,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    timeunit 1ns;
    timeprecision 100ps;

    always_ff @(posedge cap) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/xcvr_sel_mux.sv
module xcvr_sel_mux #(
    parameter int WIDTH = 8
) (
    input  logic             use_stored,
    input  logic [WIDTH-1:0] live,
    input  logic [WIDTH-1:0] stored,
    output logic [WIDTH-1:0] y
);
    timeunit 1ns;
    timeprecision 100ps;

    always_comb begin
        y = use_stored ? stored : live;
    end
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
    import xcvr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             rst,
    input  logic             cap_ab,
    input  logic             cap_ba,
    input  lane_ctl_t        ctl,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] a_out,
    output logic [WIDTH-1:0] b_out,
    output logic             a_oe,
    output logic             b_oe,
    output logic [WIDTH-1:0] held_ab,
    output logic [WIDTH-1:0] held_ba
);
    timeunit 1ns;
    timeprecision 100ps;

    drive_t drv;

    xcvr_store_reg #(.WIDTH(WIDTH)) u_reg_ab (
        .cap (cap_ab),
        .rst (rst),
        .d   (a_in),
        .q   (held_ab)
    );

    xcvr_store_reg #(.WIDTH(WIDTH)) u_reg_ba (
        .cap (cap_ba),
        .rst (rst),
        .d   (b_in),
        .q   (held_ba)
    );

    xcvr_sel_mux #(.WIDTH(WIDTH)) u_mux_to_b (
        .use_stored (ctl.stored_to_b),
        .live       (a_in),
        .stored     (held_ab),
        .y          (b_out)
    );

    xcvr_sel_mux #(.WIDTH(WIDTH)) u_mux_to_a (
        .use_stored (ctl.stored_to_a),
        .live       (b_in),
        .stored     (held_ba),
        .y          (a_out)
    );

    always_comb begin
        drv  = drive_of(ctl);
        a_oe = (drv == DRV_A);
        b_oe = (drv == DRV_B);
    end
endmodule

// File: rtl/xcvr_regbus.sv
module xcvr_regbus
    import xcvr_pkg::*;
#(
    parameter int WIDTH    = 8,
    parameter int CHANNELS = 2
) (
    input  logic                      rst,
    input  logic [CHANNELS-1:0]       isolate,
    input  logic [CHANNELS-1:0]       dir_to_b,
    input  logic [CHANNELS-1:0]       sel_ab,
    input  logic [CHANNELS-1:0]       sel_ba,
    input  logic [CHANNELS-1:0]       cap_ab,
    input  logic [CHANNELS-1:0]       cap_ba,
    input  logic [CHANNELS*WIDTH-1:0] a_in,
    input  logic [CHANNELS*WIDTH-1:0] b_in,
    output logic [CHANNELS*WIDTH-1:0] a_out,
    output logic [CHANNELS*WIDTH-1:0] b_out,
    output logic [CHANNELS-1:0]       a_oe,
    output logic [CHANNELS-1:0]       b_oe
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam int BUS_W = CHANNELS * WIDTH;

    logic [BUS_W-1:0] held_ab;
    logic [BUS_W-1:0] held_ba;

    for (genvar k = 0; k < CHANNELS; k++) begin : g_lane
        lane_ctl_t ctl;

        always_comb begin
            ctl.isolate     = isolate[k];
            ctl.dir_to_b    = dir_to_b[k];
            ctl.stored_to_b = sel_ab[k];
            ctl.stored_to_a = sel_ba[k];
        end

        xcvr_lane #(.WIDTH(WIDTH)) u_lane (
            .rst     (rst),
            .cap_ab  (cap_ab[k]),
            .cap_ba  (cap_ba[k]),
            .ctl     (ctl),
            .a_in    (a_in[k*WIDTH +: WIDTH]),
            .b_in    (b_in[k*WIDTH +: WIDTH]),
            .a_out   (a_out[k*WIDTH +: WIDTH]),
            .b_out   (b_out[k*WIDTH +: WIDTH]),
            .a_oe    (a_oe[k]),
            .b_oe    (b_oe[k]),
            .held_ab (held_ab[k*WIDTH +: WIDTH]),
            .held_ba (held_ba[k*WIDTH +: WIDTH])
        );
    end
endmodule

// File: rtl/xcvr_regbus_chk.sv
module xcvr_regbus_chk #(
    parameter int WIDTH    = 8,
    parameter int CHANNELS = 2
) (
    input logic                      rst,
    input logic [CHANNELS-1:0]       isolate,
    input logic [CHANNELS-1:0]       dir_to_b,
    input logic [CHANNELS-1:0]       sel_ab,
    input logic [CHANNELS-1:0]       sel_ba,
    input logic [CHANNELS-1:0]       cap_ab,
    input logic [CHANNELS-1:0]       cap_ba,
    input logic [CHANNELS*WIDTH-1:0] a_in,
    input logic [CHANNELS*WIDTH-1:0] b_in,
    input logic [CHANNELS*WIDTH-1:0] a_out,
    input logic [CHANNELS*WIDTH-1:0] b_out,
    input logic [CHANNELS-1:0]       a_oe,
    input logic [CHANNELS-1:0]       b_oe,
    input logic [CHANNELS*WIDTH-1:0] held_ab,
    input logic [CHANNELS*WIDTH-1:0] held_ba
);
    timeunit 1ns;
    timeprecision 100ps;

    for (genvar k = 0; k < CHANNELS; k++) begin : g_chk
        always_comb begin
            AST_ONE_DRIVER: assert (!(a_oe[k] && b_oe[k])); // R8
            AST_ISOLATE_QUIET: assert (!isolate[k] || (!a_oe[k] && !b_oe[k])); // R4
            AST_DIR_SELECT: assert (isolate[k] || (b_oe[k] == dir_to_b[k] && a_oe[k] == !dir_to_b[k])); // R5
            AST_A_SOURCE: assert (a_out[k*WIDTH +: WIDTH] == (sel_ba[k] ? held_ba[k*WIDTH +: WIDTH] : b_in[k*WIDTH +: WIDTH])); // R6
            AST_B_SOURCE: assert (b_out[k*WIDTH +: WIDTH] == (sel_ab[k] ? held_ab[k*WIDTH +: WIDTH] : a_in[k*WIDTH +: WIDTH])); // R7
        end

        AST_LOAD_AB: assert property (@(posedge cap_ab[k]) disable iff (rst)
            !rst |=> held_ab[k*WIDTH +: WIDTH] == $past(a_in[k*WIDTH +: WIDTH])); // R1

        AST_LOAD_BA: assert property (@(posedge cap_ba[k]) disable iff (rst)
            !rst |=> held_ba[k*WIDTH +: WIDTH] == $past(b_in[k*WIDTH +: WIDTH])); // R1

        AST_CLEAR_AB: assert property (@(posedge cap_ab[k])
            rst |=> held_ab[k*WIDTH +: WIDTH] == '0); // R10

        AST_CLEAR_BA: assert property (@(posedge cap_ba[k])
            rst |=> held_ba[k*WIDTH +: WIDTH] == '0); // R10
    end
endmodule

bind xcvr_regbus xcvr_regbus_chk #(.WIDTH(WIDTH), .CHANNELS(CHANNELS)) u_chk (.*);

// File: tb/xcvr_regbus_test.sv
module xcvr_regbus_test;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int W  = 4;
    localparam int CH = 2;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic            rst;
    logic [CH-1:0]   isolate, dir_to_b, sel_ab, sel_ba, cap_ab, cap_ba;
    logic [CH*W-1:0] a_in, b_in, a_out, b_out;
    logic [CH-1:0]   a_oe, b_oe;

    logic [W-1:0] m_ab [CH];
    logic [W-1:0] m_ba [CH];

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    xcvr_regbus #(.WIDTH(W), .CHANNELS(CH)) uut (
        .rst(rst), .isolate(isolate), .dir_to_b(dir_to_b),
        .sel_ab(sel_ab), .sel_ba(sel_ba), .cap_ab(cap_ab), .cap_ba(cap_ba),
        .a_in(a_in), .b_in(b_in), .a_out(a_out), .b_out(b_out),
        .a_oe(a_oe), .b_oe(b_oe)
    );

    task automatic note(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected outputs, computed from the requirements
    task automatic check_all(input string req);
        logic [CH*W-1:0] ea, eb;
        logic [CH-1:0]   eoa, eob;
        logic [31:0]     act, exp;
        #1;
        for (int c = 0; c < CH; c++) begin
            ea[c*W +: W] = sel_ba[c] ? m_ba[c] : b_in[c*W +: W];
            eb[c*W +: W] = sel_ab[c] ? m_ab[c] : a_in[c*W +: W];
            eoa[c] = !isolate[c] && !dir_to_b[c];
            eob[c] = !isolate[c] && dir_to_b[c];
        end
        act = 32'({a_oe, b_oe, a_out, b_out});
        exp = 32'({eoa, eob, ea, eb});
        note(act === exp, req, act, exp);
    endtask

    task automatic pulse(input logic [CH-1:0] ab, input logic [CH-1:0] ba);
        @(negedge clk);
        cap_ab = ab;
        cap_ba = ba;
        for (int c = 0; c < CH; c++) begin
            if (ab[c]) m_ab[c] = rst ? '0 : a_in[c*W +: W];
            if (ba[c]) m_ba[c] = rst ? '0 : b_in[c*W +: W];
        end
        @(negedge clk);
        cap_ab = '0;
        cap_ba = '0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; isolate = '1; dir_to_b = '0; sel_ab = '0; sel_ba = '0;
        cap_ab = '0; cap_ba = '0; a_in = 8'h96; b_in = 8'h3c;
        for (int c = 0; c < CH; c++) begin m_ab[c] = 'x; m_ba[c] = 'x; end

        // R10: clear on capture edges with rst high
        pulse('1, '1);
        rst = 1'b0;
        sel_ab = '1; sel_ba = '1;
        check_all("R10 reset clears, R4 isolated");

        // R2: load in isolation
        @(negedge clk); a_in = 8'h5a; b_in = 8'hc3;
        pulse('1, '1);
        check_all("R2 load while isolated");

        // R3: hold without edges
        @(negedge clk); a_in = 8'h11; b_in = 8'hee; isolate = '0; dir_to_b = 2'b01;
        check_all("R3 hold without capture edge");

        // R2: load undriven A side while lane 0 drives B
        pulse(2'b01, 2'b00);
        check_all("R2 R9 undriven side loaded, lane1 untouched");

        // R1: both clocks on the same edge, lane 1 drives A
        @(negedge clk); a_in = 8'h7d; b_in = 8'h28;
        pulse(2'b10, 2'b10);
        check_all("R1 simultaneous capture lane1");

        // R10 R9: clear lane 1 A-to-B only
        @(negedge clk); rst = 1'b1;
        pulse(2'b10, 2'b00);
        @(negedge clk); rst = 1'b0;
        check_all("R10 R9 selective clear");

        // R5..R8: exhaustive sweep per lane
        @(negedge clk); a_in = 8'h94; b_in = 8'h6b;
        pulse('1, '1);
        for (int ch = 0; ch < CH; ch++) begin
            for (int ctl = 0; ctl < 16; ctl++) begin
                for (int d = 0; d < 256; d++) begin
                    @(negedge clk);
                    isolate[ch]  = ctl[3];
                    dir_to_b[ch] = ctl[2];
                    sel_ab[ch]   = ctl[1];
                    sel_ba[ch]   = ctl[0];
                    a_in[ch*W +: W] = d[3:0];
                    b_in[ch*W +: W] = d[7:4];
                    check_all("R5 R6 R7 R8 R9 sweep");
                end
            end
            isolate[ch] = 1'b1;
        end

        // R3: outputs in stored mode unaffected by bus changes
        @(negedge clk); sel_ab = '1; sel_ba = '1; a_in = 8'hff; b_in = 8'h00;
        check_all("R3 stored mode ignores bus inputs");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule